// File: doc/BRIEF.md
# Two-Speed Successive-Approximation Conversion Controller

This block runs a successive-approximation conversion around an external DAC and an external comparator. It resolves bits from the most significant one downwards. For each bit it drives a trial code to the DAC, waits a settling interval, samples the comparator, and then keeps or clears the trial bit. The upper decisions get a long settling interval and the lower decisions a short one. This spends time where the DAC's largest steps need it. A length input can stop the conversion early, and the bits that are not resolved stay zero.

A single run/hold input sets the operating mode. Held low, the controller starts a new conversion as soon as the previous one finishes. Held high, it stops after the current conversion and waits for the input to fall. A mode input selects unipolar straight binary or bipolar two's-complement results. In bipolar mode the sign bit is decided with the inverse sense. The busy output is high while a conversion runs, and its falling edge marks a new valid result.

Top module: `sar_two_speed_ctrl`

## Requirements
- R1: Bits are resolved most significant first. The comparator input `cmp_i` is 1 when the analog input is at or above the DAC output. In unipolar mode (`bipolar_i` = 0) a trial bit is kept when `cmp_i` is 1. The first trial code is 14'h2000, and a full conversion gives floor(input) as the result.
- R2: Each of the first `SLOW_BITS` decisions (default 8) takes `SLOW_CYC` clock cycles (default 6). Each later decision takes `FAST_CYC` cycles (default 2). `busy_o` stays high for exactly the sum of the step periods of one conversion.
- R3: A `len_i` value from 1 to 14 resolves that many bits, and the lower bits of the result are zero. A value of 0, or any value above 14, resolves all 14 bits.
- R4: In bipolar mode (`bipolar_i` = 1) the sign-bit step presents code 0 to the DAC. The sign bit is set when `cmp_i` is 0. The other bits follow the R1 rule, so the result is the two's-complement floor of the input.
- R5: With `hold_run_i` held low, `busy_o` goes low for exactly one cycle between back-to-back conversions. A new result is published at each completion.
- R6: If `hold_run_i` is high when a conversion completes, the controller stops. `busy_o` then stays low and `result_o` stays unchanged for as long as `hold_run_i` stays high.
- R7: A stopped controller starts a conversion on the first clock edge at which `hold_run_i` is low after having been high. This includes leaving reset with `hold_run_i` low.
- R8: `result_o` changes only at the edge where `busy_o` falls. During a conversion it keeps the previous result.
- R9: The values of `bipolar_i` and `len_i` are captured when a conversion starts. Changing them during the conversion does not affect its result.
- R10: While reset is asserted, and after it is released with `hold_run_i` high, `busy_o`, `result_o` and `dac_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hold_run_i | input | 1 | Low: free-running; high: stop after the current conversion; a fall restarts |
| bipolar_i | input | 1 | 1 selects two's-complement result with inverted sign-bit decision |
| len_i | input | 4 | Number of bits to resolve (0 or above 14 means 14) |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above the DAC output |
| dac_code_o | output | 14 | Trial code to the DAC |
| result_o | output | 14 | Last completed conversion result |
| busy_o | output | 1 | High while a conversion runs |

## Verification
The bench models the comparator from the DAC code and an analog value that the bench chooses. Unipolar runs use the extreme codes zero and full scale, a mid-scale boundary and irregular values. These separate an inverted keep rule, an off-by-one bit order and bad handling of the lowest bit. Bipolar runs use the most negative value, minus one, zero and the most positive value, which isolates the inverted sign-bit decision. Runs shortened to 1, 5, 8, 9 and 14 bits, plus out-of-range lengths, measure busy time exactly. These tell the slow/fast boundary apart from the truncation point.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Sequencer states: stopped, converting, one-cycle completion.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DONE = 2'd2
  } sar_state_e;

endpackage

// File: rtl/sar_step_timer.sv
// Settling-interval down-counter; reloads with the slow or fast period.
module sar_step_timer #(
  parameter int SLOW_CYC = 6,
  parameter int FAST_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic slow_i,
  output logic expire_o
);

  localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] SLOW_LD = CW'(SLOW_CYC - 1);
  localparam logic [CW-1:0] FAST_LD = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] MAX_LD  = CW'(MAX_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = slow_i ? SLOW_LD : FAST_LD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = (cnt_q == '0);

  // R2: the counter never exceeds the longest settling period.
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_LD);

  // R2: after a reload the interval runs at least one full count before expiring,
  // unless the reload value is zero.
  assert_no_early_expire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && slow_i && (SLOW_CYC > 1)) |=> !expire_o);

endmodule

// File: rtl/sar_approx_reg.sv
// Approximation register: cleared at start, one bit written per decision.
module sar_approx_reg #(
  parameter int WIDTH = 14,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             decide_i,
  input  logic             conv_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             keep_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] acc_next_o
);

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] acc_d;
  logic             acc_en;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic hit;
    assign hit      = decide_i && (idx_i == IW'(b));
    assign acc_d[b] = start_i ? 1'b0 : (hit ? keep_i : acc_q[b]);
  end

  assign acc_en = start_i || decide_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o      = acc_q;
  assign acc_next_o = acc_d;

  // R3: while converting, no bit below the current trial position is ever set.
  logic [WIDTH-1:0] below_mask;
  assign below_mask = (WIDTH'(1) << idx_i) - WIDTH'(1);

  assert_low_bits_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_i |-> ((acc_q & below_mask) == '0));

endmodule

// File: rtl/sar_seq_fsm.sv
// Conversion sequencer: run/hold handling, step count, mode and length capture.
module sar_seq_fsm
  import sar_pkg::*;
#(
  parameter int WIDTH     = 14,
  parameter int SLOW_BITS = 8,
  parameter int LW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          bipolar_i,
  input  logic [LW-1:0] len_i,
  input  logic          expire_i,
  output logic          busy_o,
  output logic          start_o,
  output logic          decide_o,
  output logic          last_o,
  output logic [LW-1:0] step_o,
  output logic          bip_o,
  output logic          load_slow_o
);

  sar_state_e    state_q, state_d;
  logic [LW-1:0] step_q, step_d;
  logic [LW-1:0] len_q, len_d;
  logic          bip_q, bip_d;
  logic          hold_q;
  logic [LW-1:0] len_eff;
  logic          hold_fall;

  assign len_eff   = ((len_i == '0) || (int'(len_i) > WIDTH)) ? LW'(WIDTH) : len_i;
  assign hold_fall = hold_q && !hold_i;

  assign busy_o   = (state_q == ST_CONV);
  assign decide_o = busy_o && expire_i;
  assign last_o   = (step_q == (len_q - LW'(1)));

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hold_fall) begin
          state_d = ST_CONV;
          start_o = 1'b1;
        end
      end
      ST_CONV: begin
        if (expire_i && last_o) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!hold_i) begin
          state_d = ST_CONV;
          start_o = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    step_d = step_q;
    len_d  = len_q;
    bip_d  = bip_q;
    if (start_o) begin
      step_d = '0;
      len_d  = len_eff;
      bip_d  = bipolar_i;
    end else if (decide_o && !last_o) begin
      step_d = step_q + LW'(1);
    end
  end

  assign load_slow_o = start_o ? (SLOW_BITS > 0) : ((int'(step_q) + 1) < SLOW_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      len_q  <= LW'(WIDTH);
      bip_q  <= 1'b0;
    end else if (start_o || decide_o) begin
      step_q <= step_d;
      len_q  <= len_d;
      bip_q  <= bip_d;
    end
  end

  assign step_o = step_q;
  assign bip_o  = bip_q;

  // R7: a conversion is never launched while the run/hold input is high.
  assert_start_needs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !hold_i);

  // R1: each non-final decision advances exactly one bit position.
  assert_step_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_o && !last_o) |=> (step_q == $past(step_q) + LW'(1)));

  // R5: the completion state lasts a single cycle.
  assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q != ST_DONE));

  // R9: the captured length stays fixed throughout a conversion.
  assert_len_captured_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(start_o)) |-> $stable(len_q));

endmodule

// File: rtl/sar_two_speed_ctrl.sv
// Top: two-speed successive-approximation conversion controller.
module sar_two_speed_ctrl #(
  parameter int WIDTH     = 14,
  parameter int SLOW_BITS = 8,
  parameter int SLOW_CYC  = 6,
  parameter int FAST_CYC  = 2,
  parameter int LW        = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_run_i,
  input  logic             bipolar_i,
  input  logic [LW-1:0]    len_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o
);

  localparam logic [LW-1:0] MSB_IDX = LW'(WIDTH - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic          busy, start, decide, last, bip, load_slow, expire;
  logic [LW-1:0] step, idx;
  logic          sign_step, keep;
  logic [WIDTH-1:0] acc, acc_next, trial;
  logic [WIDTH-1:0] result_q, result_d;
  logic             result_en;

  sar_seq_fsm #(
    .WIDTH     (WIDTH),
    .SLOW_BITS (SLOW_BITS),
    .LW        (LW)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .hold_i      (hold_run_i),
    .bipolar_i   (bipolar_i),
    .len_i       (len_i),
    .expire_i    (expire),
    .busy_o      (busy),
    .start_o     (start),
    .decide_o    (decide),
    .last_o      (last),
    .step_o      (step),
    .bip_o       (bip),
    .load_slow_o (load_slow)
  );

  sar_step_timer #(
    .SLOW_CYC (SLOW_CYC),
    .FAST_CYC (FAST_CYC)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_i   (start || (decide && !last)),
    .slow_i   (load_slow),
    .expire_o (expire)
  );

  assign idx       = MSB_IDX - step;
  assign sign_step = bip && (step == '0);
  // Bipolar sign bit: trial presents midscale (bit clear), decision inverted.
  assign keep      = sign_step ? !cmp_i : cmp_i;

  sar_approx_reg #(
    .WIDTH (WIDTH),
    .IW    (LW)
  ) approx_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_i    (start),
    .decide_i   (decide),
    .conv_i     (busy),
    .idx_i      (idx),
    .keep_i     (keep),
    .acc_o      (acc),
    .acc_next_o (acc_next)
  );

  always_comb begin
    trial = '0;
    if (busy && !sign_step) begin
      trial = WIDTH'(1) << idx;
    end
  end

  assign dac_code_o = acc | trial;

  assign result_en = decide && last;
  assign result_d  = acc_next;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      result_q <= '0;
    end else if (result_en) begin
      result_q <= result_d;
    end
  end

  assign result_o = result_q;
  assign busy_o   = busy;

  // R8: the published result moves only on the edge where busy falls.
  assert_result_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (result_q != $past(result_q)) |-> $fell(busy));

  // R6: idle with hold high stays idle on the next cycle.
  assert_hold_keeps_stopped_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!busy && hold_run_i) |=> !busy);

  // R4: in the bipolar sign step the DAC sees the midscale code.
  assert_sign_trial_mid_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && sign_step) |-> (dac_code_o == '0));

endmodule

// File: tb/sar_two_speed_ctrl_tb_top.sv
module sar_two_speed_ctrl_tb_top;

  localparam int W  = 14;
  localparam int SB = 8;
  localparam int SC = 6;
  localparam int FC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hold_run;
  logic        bip;
  logic [3:0]  len;
  logic        cmp;
  logic [13:0] dac;
  logic [13:0] result;
  logic        busy;

  int  vin;
  bit  model_bip;
  int  dv;
  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  sar_two_speed_ctrl #(
    .WIDTH (W), .SLOW_BITS (SB), .SLOW_CYC (SC), .FAST_CYC (FC)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_run_i (hold_run),
    .bipolar_i  (bip),
    .len_i      (len),
    .cmp_i      (cmp),
    .dac_code_o (dac),
    .result_o   (result),
    .busy_o     (busy)
  );

  // Comparator model: analog input against the DAC value.
  always_comb begin
    dv = int'(dac);
    if (model_bip && dac[13]) dv = dv - 16384;
    cmp = (vin >= dv);
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_len(int l);
    return (l == 0 || l > 14) ? 14 : l;
  endfunction

  function automatic int exp_code(int v, int n, bit b);
    int s, u;
    s = 14 - n;
    if (b) begin
      u = v + 8192;
      u = (u >> s) << s;
      return (u ^ 8192) & 16383;
    end
    return (v >> s) << s;
  endfunction

  function automatic int exp_cycles(int n);
    return ((n < SB) ? n : SB) * SC + ((n > SB) ? (n - SB) : 0) * FC;
  endfunction

  task automatic apply_reset(bit hold_level);
    hold_run = hold_level;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R10: reset state with hold high.
  task automatic t_reset_state();
    bip = 0; len = 0; vin = 0; model_bip = 0;
    apply_reset(1'b1);
    chk("R10 busy in reset", int'(busy), 0);
    chk("R10 result in reset", int'(result), 0);
    repeat (5) @(negedge clk);
    chk("R10 busy after release", int'(busy), 0);
    chk("R10 result after release", int'(result), 0);
    chk("R10 dac after release", int'(dac), 0);
  endtask

  // One-shot conversion via a one-cycle low pulse on hold (R1 R2 R3 R4 R6 R7 R8).
  task automatic t_one_shot(int v, int l, bit b);
    int n, cyc, prev;
    n = eff_len(l);
    vin = v; len = 4'(l); bip = b; model_bip = b;
    prev = int'(result);
    @(negedge clk); hold_run = 0;
    @(negedge clk); hold_run = 1;
    chk("R7 busy after low pulse", int'(busy), 1);
    chk(b ? "R4 sign-step trial code" : "R1 first trial code", int'(dac), b ? 0 : 8192);
    chk("R8 result held during conversion", int'(result), prev);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    chk(b ? "R4 bipolar result" : (n < 14 ? "R3 short result" : "R1 result"),
        int'(result), exp_code(v, n, b));
    chk("R2 busy duration", cyc, exp_cycles(n));
    prev = int'(result);
    repeat (20) @(negedge clk);
    chk("R6 stays stopped", int'(busy), 0);
    chk("R6 result stable when stopped", int'(result), prev);
  endtask

  // R5: back-to-back conversions with hold low.
  task automatic t_free_run();
    int vals[4];
    vals[0] = 1234; vals[1] = 16383; vals[2] = 0; vals[3] = 9000;
    bip = 0; len = 0; model_bip = 0;
    vin = vals[0];
    @(negedge clk); hold_run = 0;
    @(negedge clk);
    chk("R5 free-run start", int'(busy), 1);
    for (int i = 0; i < 3; i++) begin
      while (busy) @(negedge clk);
      chk("R5 free-run result", int'(result), exp_code(vals[i], 14, 0));
      vin = vals[i + 1];
      @(negedge clk);
      chk("R5 busy low one cycle", int'(busy), 1);
    end
    hold_run = 1;
    while (busy) @(negedge clk);
    chk("R5 last free-run result", int'(result), exp_code(vals[3], 14, 0));
    repeat (10) @(negedge clk);
    chk("R6 stop after free run", int'(busy), 0);
  endtask

  // R9: mode and length changed mid-conversion have no effect.
  task automatic t_capture();
    vin = 777; len = 4'd6; bip = 0; model_bip = 0;
    @(negedge clk); hold_run = 0;
    @(negedge clk); hold_run = 1;
    repeat (3) @(negedge clk);
    len = 4'd14; bip = 1;
    while (busy) @(negedge clk);
    chk("R9 captured mode and length", int'(result), exp_code(777, 6, 0));
    bip = 0; len = 0;
  endtask

  // R7: leaving reset with hold low starts a conversion.
  task automatic t_reset_hold_low();
    vin = 4321; bip = 0; len = 0; model_bip = 0;
    apply_reset(1'b0);
    repeat (4) @(negedge clk);
    chk("R7 start from reset with hold low", int'(busy), 1);
    hold_run = 1;
    while (busy) @(negedge clk);
    chk("R7 result after reset start", int'(result), exp_code(4321, 14, 0));
  endtask

  initial begin
    hold_run = 1; bip = 0; len = 0; vin = 0; model_bip = 0; rst_n = 0;
    t_reset_state();
    t_one_shot(0, 0, 0);
    t_one_shot(16383, 14, 0);
    t_one_shot(8192, 0, 0);
    t_one_shot(8191, 0, 0);
    t_one_shot(10923, 15, 0);
    t_one_shot(12345, 1, 0);
    t_one_shot(12345, 5, 0);
    t_one_shot(12345, 8, 0);
    t_one_shot(12345, 9, 0);
    t_one_shot(-8192, 0, 1);
    t_one_shot(-1, 0, 1);
    t_one_shot(0, 0, 1);
    t_one_shot(8191, 0, 1);
    t_one_shot(-3000, 7, 1);
    t_free_run();
    t_capture();
    t_reset_hold_low();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule